// File: doc/BRIEF.md
# Alternating Two-Bank Frame Store Controller

This block sits between an 8-bit camera pixel stream and a byte-wide transfer engine. Two external asynchronous SRAM banks are used, each large enough for one whole frame (1280 × 1024 pixels by default, inside a 2M-byte address space). Incoming frames fill the banks in strict alternation. A bank that holds a finished frame is read out in address order while the next frame is written into the other bank, so capture and transfer run at the same time.

Ownership is decided by two independent locks. The write lock lets at most one bank be the capture target. The read lock lets at most one bank be the readout source. Banks only change hands at frame boundaries. Because the reader drains a bank much faster than the camera fills one, an emptied bank waits idle until its turn in the alternation comes round. A frame that begins when its target bank is not yet free is discarded whole, and a sticky flag records the loss.

Top module: `pp_frame_store`

## Requirements
- R1: After reset `out_valid`, `overflow`, `bank_full` and all SRAM strobes are 0 and `cur_wbank` is 0. The first accepted frame is written into bank 0.
- R2: Each frame's write address starts at 0 and rises by one for every cycle in which `pix_lv` is high. A cycle with `pix_lv` low writes nothing. A pixel in the same cycle as `pix_fs` is not captured.
- R3: At most one bank has `sram_we` high in any cycle. Writes go only to the bank that owns the write lock.
- R4: At most one bank has `sram_oe` high in any cycle. Reads come only from the bank that owns the read lock.
- R5: After FRAME_PIX pixels the frame is complete. Its bank's `bank_full` bit (bit index = bank number) goes high, and `cur_wbank` points to the other bank.
- R6: A completed bank is readable with no added wait. If the read lock is free, `out_valid` is still 0 one cycle after the edge that samples the last pixel, and it is 1 two cycles after that edge.
- R7: Readout delivers the bank's bytes in address order 0 to FRAME_PIX−1 over a ready/valid handshake. `out_data` is held while `out_valid` is high and `out_ready` is low. When both banks are full, the older frame is read first.
- R8: A bank emptied by the reader receives no writes while the other bank captures its frame. The write target strictly alternates between the banks.
- R9: A `pix_fs` that arrives with no capture in progress and with the target bank not empty drops the whole frame. No SRAM write happens, the target stays the same, and `overflow` is set and stays high until reset.
- R10: A `pix_fs` during a capture restarts that capture at address 0 in the same bank.
- R11: An SRAM access lasts one cycle. A write drives `sram_cs` and `sram_we` with `sram_oe` low. A read drives `sram_cs` and `sram_oe` with `sram_we` low. The address stays below FRAME_PIX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_fs | input | 1 | Frame-start pulse |
| pix_lv | input | 1 | Pixel valid (line valid) |
| pix_data | input | PIX_W | Pixel value |
| sram_addr | output | 2×ADDR_W | Address per bank |
| sram_wdata | output | 2×PIX_W | Write data per bank |
| sram_rdata | input | 2×PIX_W | Read data per bank |
| sram_cs | output | 2 | Chip select per bank, active high |
| sram_we | output | 2 | Write strobe per bank, active high |
| sram_oe | output | 2 | Output enable per bank, active high |
| out_valid | output | 1 | Byte available |
| out_ready | input | 1 | Consumer accepts byte |
| out_data | output | PIX_W | Byte stream |
| bank_full | output | 2 | Bank holds a finished, not yet drained frame |
| cur_wbank | output | 1 | Bank being written, or the next write target when idle |
| overflow | output | 1 | Sticky: a frame was dropped |

## Verification
The hardest situation to reach is a dropped frame. It needs both banks to be occupied at once: one bank stalled mid-readout and the other holding a finished frame, with a third frame start arriving. The bench holds `out_ready` low, so the first frame's bank stays locked for reading. It then sends a second frame into the other bank and a third that must be discarded. Afterwards it releases the reader with an irregular ready pattern and checks that the stream carries exactly the first two frames, oldest first, with no trace of the third.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

  typedef enum logic [1:0] {
    BK_EMPTY = 2'd0,
    BK_FILL  = 2'd1,
    BK_FULL  = 2'd2,
    BK_READ  = 2'd3
  } bank_st_t;

  // true when idx is the final position of a frame of total entries
  function automatic logic at_last(input logic [31:0] idx, input logic [31:0] total);
    return idx == (total - 32'd1);
  endfunction

  // choose read source: {valid, bank}; oldest finished frame first,
  // a bank finishing this cycle only when nothing older waits
  function automatic logic [1:0] pick_src(input logic [1:0] full, input logic newest,
                                          input logic done_v, input logic done_b);
    if (full[~newest]) return {1'b1, ~newest};
    if (full[newest])  return {1'b1, newest};
    if (done_v)        return {1'b1, done_b};
    return 2'b00;
  endfunction

endpackage

// File: rtl/pfs_capture.sv
module pfs_capture
  import pfs_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int ADDR_W    = 21,
  parameter int FRAME_PIX = 1310720
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_fs,
  input  logic              pix_lv,
  input  logic [PIX_W-1:0]  pix_data,
  input  logic              tgt_bank,
  input  logic              tgt_free,
  output logic              claim,
  output logic              cap_active,
  output logic              cap_bank,
  output logic              overflow,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [PIX_W-1:0]  wr_data,
  output logic              wr_bank,
  output logic              wr_last
);

  logic [ADDR_W-1:0] cnt_q;
  logic              pix_take;
  logic              pix_final;

  assign claim     = pix_fs && !cap_active && tgt_free;
  assign pix_take  = !pix_fs && cap_active && pix_lv;
  assign pix_final = at_last(32'(cnt_q), 32'(FRAME_PIX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_active <= 1'b0;
      cap_bank   <= 1'b0;
      cnt_q      <= '0;
      overflow   <= 1'b0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      wr_bank    <= 1'b0;
      wr_last    <= 1'b0;
    end else begin
      wr_en   <= 1'b0;
      wr_last <= 1'b0;
      if (pix_fs) begin
        if (cap_active) begin
          cnt_q <= '0;
        end else if (tgt_free) begin
          cap_active <= 1'b1;
          cap_bank   <= tgt_bank;
          cnt_q      <= '0;
        end else begin
          overflow <= 1'b1;
        end
      end else if (pix_take) begin
        wr_en   <= 1'b1;
        wr_addr <= cnt_q;
        wr_data <= pix_data;
        wr_bank <= cap_bank;
        wr_last <= pix_final;
        cnt_q   <= cnt_q + 1'b1;
        if (pix_final) cap_active <= 1'b0;
      end
    end
  end

  p_overflow_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_wr_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(wr_addr) < 32'(FRAME_PIX)));

  p_wr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_last && !pix_fs && cap_active && pix_lv) |=> (wr_addr == $past(wr_addr) + 1'b1));

  p_drop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_fs && !cap_active && !tgt_free) |=> (!cap_active && !wr_en));

endmodule

// File: rtl/pfs_bank_arb.sv
module pfs_bank_arb
  import pfs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       claim,
  input  logic       wr_en,
  input  logic       wr_bank,
  input  logic       wr_last,
  input  logic       rd_issue,
  input  logic       rd_bank,
  input  logic       rd_release,
  output logic       tgt_bank,
  output logic       tgt_free,
  output logic       grant,
  output logic       grant_bank,
  output logic [1:0] bank_full
);

  bank_st_t   st_q [2];
  logic       newest_q;
  logic [1:0] full_vec;
  logic [1:0] read_vec;
  logic [1:0] fill_vec;
  logic       lock_free;
  logic       done_v;
  logic [1:0] pick;

  always_comb begin
    for (int b = 0; b < 2; b++) begin
      full_vec[b] = (st_q[b] == BK_FULL);
      read_vec[b] = (st_q[b] == BK_READ);
      fill_vec[b] = (st_q[b] == BK_FILL);
    end
  end

  assign tgt_bank   = ~newest_q;
  assign tgt_free   = (st_q[tgt_bank] == BK_EMPTY);
  assign lock_free  = (read_vec == 2'b00);
  assign done_v     = wr_en && wr_last;
  assign pick       = pick_src(full_vec, newest_q, done_v, wr_bank);
  assign grant      = lock_free && pick[1];
  assign grant_bank = pick[0];
  assign bank_full  = full_vec | read_vec;

  function automatic bank_st_t step(input bank_st_t cur, input logic b);
    case (cur)
      BK_EMPTY: return (claim && tgt_bank == b) ? BK_FILL : BK_EMPTY;
      BK_FILL: begin
        if (done_v && wr_bank == b)
          return (grant && grant_bank == b) ? BK_READ : BK_FULL;
        return BK_FILL;
      end
      BK_FULL: return (grant && grant_bank == b) ? BK_READ : BK_FULL;
      default: return rd_release ? BK_EMPTY : BK_READ;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q[0]  <= BK_EMPTY;
      st_q[1]  <= BK_EMPTY;
      newest_q <= 1'b1;
    end else begin
      st_q[0] <= step(st_q[0], 1'b0);
      st_q[1] <= step(st_q[1], 1'b1);
      if (claim) newest_q <= tgt_bank;
    end
  end

  p_one_writer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fill_vec) <= 1);

  p_one_reader_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(read_vec) <= 1);

  p_write_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (st_q[wr_bank] == BK_FILL));

  p_read_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue |-> (st_q[rd_bank] == BK_READ));

  p_full_until_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_v && !grant) |=> bank_full[$past(wr_bank)]);

endmodule

// File: rtl/pfs_reader.sv
module pfs_reader
  import pfs_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int ADDR_W    = 21,
  parameter int FRAME_PIX = 1310720
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  grant,
  input  logic                  grant_bank,
  input  logic [1:0][PIX_W-1:0] rd_data,
  input  logic                  out_ready,
  output logic                  rd_issue,
  output logic                  rd_release,
  output logic                  rd_bank,
  output logic [ADDR_W-1:0]     rd_addr,
  output logic                  out_valid,
  output logic [PIX_W-1:0]      out_data
);

  logic active_q;

  assign rd_issue   = active_q && (!out_valid || out_ready);
  assign rd_release = rd_issue && at_last(32'(rd_addr), 32'(FRAME_PIX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      rd_bank   <= 1'b0;
      rd_addr   <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (grant) begin
        active_q <= 1'b1;
        rd_bank  <= grant_bank;
        rd_addr  <= '0;
      end else if (rd_issue) begin
        rd_addr <= rd_addr + 1'b1;
        if (rd_release) active_q <= 1'b0;
      end
      if (rd_issue) begin
        out_valid <= 1'b1;
        out_data  <= rd_data[rd_bank];
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_rd_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue |-> (32'(rd_addr) < 32'(FRAME_PIX)));

  p_grant_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> !active_q);

  p_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_issue && !rd_release) |=> (rd_addr == $past(rd_addr) + 1'b1));

endmodule

// File: rtl/pp_frame_store.sv
module pp_frame_store
  import pfs_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COLS   = 1280,
  parameter int ROWS   = 1024,
  parameter int ADDR_W = 21
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pix_fs,
  input  logic                   pix_lv,
  input  logic [PIX_W-1:0]       pix_data,
  output logic [1:0][ADDR_W-1:0] sram_addr,
  output logic [1:0][PIX_W-1:0]  sram_wdata,
  input  logic [1:0][PIX_W-1:0]  sram_rdata,
  output logic [1:0]             sram_cs,
  output logic [1:0]             sram_we,
  output logic [1:0]             sram_oe,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [PIX_W-1:0]       out_data,
  output logic [1:0]             bank_full,
  output logic                   cur_wbank,
  output logic                   overflow
);

  localparam int FRAME_PIX = COLS * ROWS;

  logic              tgt_bank, tgt_free, claim;
  logic              cap_active, cap_bank;
  logic              wr_en, wr_bank, wr_last;
  logic [ADDR_W-1:0] wr_addr;
  logic [PIX_W-1:0]  wr_data;
  logic              grant, grant_bank;
  logic              rd_issue, rd_release, rd_bank;
  logic [ADDR_W-1:0] rd_addr;

  pfs_capture #(.PIX_W(PIX_W), .ADDR_W(ADDR_W), .FRAME_PIX(FRAME_PIX)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .pix_fs(pix_fs), .pix_lv(pix_lv), .pix_data(pix_data),
    .tgt_bank(tgt_bank), .tgt_free(tgt_free),
    .claim(claim), .cap_active(cap_active), .cap_bank(cap_bank),
    .overflow(overflow),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_bank(wr_bank), .wr_last(wr_last)
  );

  pfs_bank_arb u_arb (
    .clk(clk), .rst_n(rst_n),
    .claim(claim),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_last(wr_last),
    .rd_issue(rd_issue), .rd_bank(rd_bank), .rd_release(rd_release),
    .tgt_bank(tgt_bank), .tgt_free(tgt_free),
    .grant(grant), .grant_bank(grant_bank),
    .bank_full(bank_full)
  );

  pfs_reader #(.PIX_W(PIX_W), .ADDR_W(ADDR_W), .FRAME_PIX(FRAME_PIX)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .grant(grant), .grant_bank(grant_bank),
    .rd_data(sram_rdata), .out_ready(out_ready),
    .rd_issue(rd_issue), .rd_release(rd_release),
    .rd_bank(rd_bank), .rd_addr(rd_addr),
    .out_valid(out_valid), .out_data(out_data)
  );

  assign cur_wbank = cap_active ? cap_bank : tgt_bank;

  for (genvar b = 0; b < 2; b++) begin : g_port
    logic wsel, rsel;
    assign wsel          = wr_en && (wr_bank == 1'(b));
    assign rsel          = rd_issue && (rd_bank == 1'(b));
    assign sram_we[b]    = wsel;
    assign sram_oe[b]    = rsel;
    assign sram_cs[b]    = wsel || rsel;
    assign sram_addr[b]  = wsel ? wr_addr : rd_addr;
    assign sram_wdata[b] = wr_data;
  end

  p_wr_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sram_we));

  p_rd_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sram_oe));

  p_no_clash_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_we & sram_oe) == 2'b00);

endmodule

// File: tb/pp_frame_store_test.sv
module pp_frame_store_test;

  localparam int PIX_W = 8;
  localparam int COLS  = 4;
  localparam int ROWS  = 4;
  localparam int AW    = 21;
  localparam int FP    = COLS * ROWS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_fs = 1'b0, pix_lv = 1'b0;
  logic [PIX_W-1:0] pix_data = '0;
  logic [1:0][AW-1:0] sram_addr;
  logic [1:0][PIX_W-1:0] sram_wdata, sram_rdata;
  logic [1:0] sram_cs, sram_we, sram_oe;
  logic out_valid, out_ready;
  logic [PIX_W-1:0] out_data;
  logic [1:0] bank_full;
  logic cur_wbank, overflow;

  always #10 clk = ~clk;

  pp_frame_store #(.PIX_W(PIX_W), .COLS(COLS), .ROWS(ROWS), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .pix_fs(pix_fs), .pix_lv(pix_lv), .pix_data(pix_data),
    .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
    .sram_cs(sram_cs), .sram_we(sram_we), .sram_oe(sram_oe),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .bank_full(bank_full), .cur_wbank(cur_wbank), .overflow(overflow)
  );

  int checks = 0, failures = 0;
  int wcount [2];
  int proto_err = 0, wlock_err = 0, rlock_err = 0;
  int ready_mode = 1;
  int cyc = 0;
  bit done = 0;
  logic [PIX_W-1:0] mem [2][FP];
  logic [PIX_W-1:0] sb_q [$];

  function automatic logic [7:0] pat(int id, int i);
    return 8'(id * 29 + i * 7 + 3);
  endfunction

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // SRAM banks and protocol watcher
  always_comb begin
    for (int b = 0; b < 2; b++)
      sram_rdata[b] = (sram_cs[b] && sram_oe[b] && sram_addr[b] < FP)
                      ? mem[b][int'(sram_addr[b])] : 8'h00;
  end

  initial begin
    wcount[0] = 0;
    wcount[1] = 0;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if ($countones(sram_we) > 1) wlock_err++;
      if ($countones(sram_oe) > 1) rlock_err++;
      for (int b = 0; b < 2; b++) begin
        if (sram_we[b] && sram_oe[b]) proto_err++;
        if ((sram_we[b] || sram_oe[b]) && !sram_cs[b]) proto_err++;
        if (sram_cs[b] && sram_addr[b] >= FP) proto_err++;
        if (sram_cs[b] && sram_we[b] && sram_addr[b] < FP) begin
          mem[b][int'(sram_addr[b])] <= sram_wdata[b];
          wcount[b]++;
        end
      end
    end
  end

  // ready pattern driver
  always @(negedge clk) begin
    case (ready_mode)
      0:       out_ready <= 1'b0;
      1:       out_ready <= 1'b1;
      default: out_ready <= (cyc % 3) != 0;
    endcase
  end

  // scoreboard monitor: a transfer happens at the next edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && out_valid && out_ready) begin
        checks++;
        if (sb_q.size() == 0) begin
          failures++;
          $display("FAIL R7 unexpected byte actual=%0d expected=none", out_data);
        end else begin
          logic [7:0] e;
          e = sb_q.pop_front();
          if (out_data !== e) begin
            failures++;
            $display("FAIL R2 R7 stream byte actual=%0d expected=%0d", out_data, e);
          end
        end
      end
    end
  end

  task automatic send_frame(int id, int n, bit push);
    @(negedge clk);
    pix_fs = 1'b1;
    pix_lv = 1'b0;
    @(negedge clk);
    pix_fs = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (i % 3 == 2) begin
        pix_lv = 1'b0;
        pix_data = 8'hEE;
        @(negedge clk);
      end
      pix_lv = 1'b1;
      pix_data = pat(id, i);
      if (push) sb_q.push_back(pat(id, i));
      @(negedge clk);
    end
    pix_lv = 1'b0;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin : main
    int w0, w1;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check("R1 out_valid", out_valid, 0);
    check("R1 bank_full", bank_full, 0);
    check("R1 cur_wbank", cur_wbank, 0);
    check("R1 overflow", overflow, 0);
    check("R1 sram_cs", sram_cs, 0);
    rst_n = 1'b1;

    // first frame, reader free
    send_frame(0, FP, 1);
    #1;
    check("R5 cur_wbank after frame", cur_wbank, 1);
    settle(1);
    check("R6 out_valid one cycle after", out_valid, 0);
    check("R5 bank0 full", bank_full, 2'b01);
    settle(1);
    check("R6 out_valid two cycles after", out_valid, 1);
    settle(40);
    check("R1 bank0 writes", wcount[0], FP);
    check("R1 bank1 writes", wcount[1], 0);
    check("R7 queue drained", sb_q.size(), 0);
    check("R7 banks empty", bank_full, 0);

    // stall reader, fill both banks, drop a third frame
    ready_mode = 0;
    send_frame(1, FP, 1);
    settle(4);
    check("R5 bank1 full", bank_full, 2'b10);
    check("R8 target alternates", cur_wbank, 0);
    send_frame(2, FP, 1);
    settle(4);
    check("R5 both full", bank_full, 2'b11);
    check("R9 no overflow yet", overflow, 0);
    w0 = wcount[0];
    w1 = wcount[1];
    send_frame(3, FP, 0);
    settle(2);
    check("R9 overflow set", overflow, 1);
    check("R9 no write bank0", wcount[0], w0);
    check("R9 no write bank1", wcount[1], w1);
    check("R9 target unchanged", cur_wbank, 1);
    check("R7 held valid", out_valid, 1);
    check("R7 held data", out_data, pat(1, 0));
    ready_mode = 2;
    settle(100);
    check("R7 older first, queue drained", sb_q.size(), 0);
    check("R9 overflow sticky", overflow, 1);
    check("R7 banks empty", bank_full, 0);

    // emptied bank0 must stay untouched while bank1 fills
    ready_mode = 1;
    check("R8 target bank1", cur_wbank, 1);
    w0 = wcount[0];
    w1 = wcount[1];
    send_frame(4, FP, 1);
    settle(40);
    check("R8 bank0 idle", wcount[0], w0);
    check("R8 bank1 filled", wcount[1], w1 + FP);
    check("R7 queue drained", sb_q.size(), 0);

    // restart inside a frame
    check("R10 target bank0", cur_wbank, 0);
    w0 = wcount[0];
    w1 = wcount[1];
    send_frame(5, 5, 0);
    #1;
    check("R10 capturing bank0", cur_wbank, 0);
    send_frame(6, FP, 1);
    settle(40);
    check("R10 bank0 writes", wcount[0], w0 + 5 + FP);
    check("R10 bank1 untouched", wcount[1], w1);
    check("R10 only restarted frame read", sb_q.size(), 0);

    check("R3 write lock", wlock_err, 0);
    check("R4 read lock", rlock_err, 0);
    check("R11 sram protocol", proto_err, 0);
    done = 1;
  end

  initial begin : watchdog
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
      end
    join_any
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule